// File: doc/BRIEF.md
# Processor Bus Slave Port

This block lets user logic appear as a memory-mapped peripheral on a synchronous embedded-processor bus. The processor sets up a 5-bit address, a read/write line and two chip selects, then pulls an active-low transfer-start strobe low for one cycle. The block answers with a single-cycle active-low acknowledge and, because it never accepts bursts, it drives an active-low burst-inhibit in the same cycle. Writes land in a small byte-wide register file. Reads return a register value on the 8-bit data bus, and the bus driver is enabled only in the acknowledge cycle.

Address 31 is a read-only status byte. Its bit 0 shows the synchronized interrupt request from user logic. The same request also drives an active-low interrupt output. User logic reads the register file through a separate combinational read port.

Top module: `bus_slave_top`

## Requirements
- R1: A transfer start is accepted only when start_n_i is low, sel_n_i is low and sel_i is high at the same clock edge. Otherwise no acknowledge is produced.
- R2: After an accepted start edge, ack_n_o is low for exactly the one following clock cycle.
- R3: burst_inh_n_o is low exactly in the cycles where ack_n_o is low.
- R4: In a write (rnw_i=0 at the start edge), the byte on wdata_i is stored at the latched address on the rising edge that ends the acknowledge cycle. It is then visible on the user read port (usr_addr_i/usr_rdata_o).
- R5: In a read (rnw_i=1 at the start edge), rdata_o carries the addressed byte during the acknowledge cycle, and data_oe_o is high.
- R6: data_oe_o is high only during the acknowledge cycle of a read. At all other times it is low and rdata_o is 0.
- R7: A start strobe sampled during the acknowledge cycle is ignored. The cycle after an acknowledge always has ack_n_o high.
- R8: irq_req_i passes through two flops. irq_n_o goes low at the second rising edge after irq_req_i rises, and returns high two edges after irq_req_i falls.
- R9: Address 31 reads back {7'b0, synchronized irq}. Writes to address 31 are ignored.
- R10: After reset, ack_n_o, burst_inh_n_o and irq_n_o are high, data_oe_o is low, and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_n_i | input | 1 | Chip select, active low |
| sel_i | input | 1 | Chip select, active high |
| addr_i | input | 5 | Byte address |
| rnw_i | input | 1 | 1 = read, 0 = write |
| start_n_i | input | 1 | Transfer start strobe, active low |
| wdata_i | input | 8 | Write data from processor |
| rdata_o | output | 8 | Read data to processor |
| data_oe_o | output | 1 | Data bus drive enable |
| ack_n_o | output | 1 | Transfer acknowledge, active low |
| burst_inh_n_o | output | 1 | Burst inhibit, active low |
| irq_req_i | input | 1 | Asynchronous interrupt request from user logic |
| irq_n_o | output | 1 | Interrupt output, active low |
| usr_addr_i | input | 5 | User read-port address |
| usr_rdata_o | output | 8 | User read-port data |

## Verification
Acknowledge, burst inhibit, output enable and read data are due in the single cycle after the start edge. The bench samples them at the falling edge inside that cycle and checks that ack_n_o is high again one cycle later. Write data is checked on the user port at the falling edge after the edge that closes the acknowledge cycle. The interrupt output and status bit are sampled at the falling edge that follows the second rising edge after the request changes, and the bench also checks that nothing has changed one edge earlier.

// File: rtl/bus_slave_pkg.sv
package bus_slave_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;
  typedef enum logic {ST_IDLE = 1'b0, ST_ACK = 1'b1} bus_st_e;
endpackage

// File: rtl/bus_slave_fsm.sv
module bus_slave_fsm
  import bus_slave_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_n_i,
  input  logic          sel_i,
  input  logic          start_n_i,
  input  logic          rnw_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_q_o,
  output logic          wr_en_o,
  output logic          rd_oe_o,
  output logic          ack_n_o,
  output logic          bi_n_o
);
  bus_st_e       state_q;
  logic [AW-1:0] addr_q;
  logic          rnw_q;
  logic          hit;

  assign hit = !start_n_i && !sel_n_i && sel_i && (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rnw_q   <= 1'b0;
      ack_n_o <= 1'b1;
      bi_n_o  <= 1'b1;
    end else if (hit) begin
      state_q <= ST_ACK;
      addr_q  <= addr_i;
      rnw_q   <= rnw_i;
      ack_n_o <= 1'b0;
      bi_n_o  <= 1'b0;
    end else begin
      state_q <= ST_IDLE;
      ack_n_o <= 1'b1;
      bi_n_o  <= 1'b1;
    end
  end

  assign addr_q_o = addr_q;
  assign wr_en_o  = (state_q == ST_ACK) && !rnw_q;
  assign rd_oe_o  = (state_q == ST_ACK) && rnw_q;

  assert_ack_needs_sel_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_n_o) |-> $past(!start_n_i && !sel_n_i && sel_i));
  assert_ack_one_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_n_o |=> ack_n_o);
  assert_bi_with_ack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bi_n_o == ack_n_o);
endmodule

// File: rtl/bus_slave_regs.sv
module bus_slave_regs
  import bus_slave_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_b_o
);
  localparam int DEPTH = 1 << AW;
  localparam int NREG  = DEPTH - 1; // top address is status

  logic [DW-1:0] mem_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (we_i && (waddr_i == AW'(g))) mem_q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = (raddr_a_i < AW'(NREG)) ? mem_q[raddr_a_i] : '0;
  assign rdata_b_o = (raddr_b_i < AW'(NREG)) ? mem_q[raddr_b_i] : '0;
endmodule

// File: rtl/bus_slave_irq_sync.sv
module bus_slave_irq_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_req_i,
  output logic irq_o
);
  logic meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= irq_req_i;
      sync_q <= meta_q;
    end
  end

  assign irq_o = sync_q;

  assert_irq_two_stage_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_q == $past(meta_q));
endmodule

// File: rtl/bus_slave_top.sv
module bus_slave_top
  import bus_slave_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_n_i,
  input  logic          sel_i,
  input  logic [AW-1:0] addr_i,
  input  logic          rnw_i,
  input  logic          start_n_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          data_oe_o,
  output logic          ack_n_o,
  output logic          burst_inh_n_o,
  input  logic          irq_req_i,
  output logic          irq_n_o,
  input  logic [AW-1:0] usr_addr_i,
  output logic [DW-1:0] usr_rdata_o
);
  localparam logic [AW-1:0] STATUS_ADDR = AW'((1 << AW) - 1);

  logic [AW-1:0] addr_q;
  logic          wr_en, rd_oe, irq_sync;
  logic [DW-1:0] reg_rd;
  logic [DW-1:0] bus_word;

  bus_slave_fsm #(.AW(AW)) u_fsm (
    .clk_i, .rst_ni, .sel_n_i, .sel_i, .start_n_i, .rnw_i, .addr_i,
    .addr_q_o(addr_q), .wr_en_o(wr_en), .rd_oe_o(rd_oe),
    .ack_n_o, .bi_n_o(burst_inh_n_o)
  );

  bus_slave_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(wr_en && (addr_q != STATUS_ADDR)),
    .waddr_i(addr_q), .wdata_i,
    .raddr_a_i(addr_q), .rdata_a_o(reg_rd),
    .raddr_b_i(usr_addr_i), .rdata_b_o(usr_rdata_o)
  );

  bus_slave_irq_sync u_irq (
    .clk_i, .rst_ni, .irq_req_i, .irq_o(irq_sync)
  );

  assign bus_word  = (addr_q == STATUS_ADDR) ? {{(DW-1){1'b0}}, irq_sync} : reg_rd;
  assign data_oe_o = rd_oe;
  assign rdata_o   = rd_oe ? bus_word : '0;
  assign irq_n_o   = ~irq_sync;

  assert_oe_only_in_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !ack_n_o);
  assert_idle_bus_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (rdata_o == '0));
  assert_no_start_in_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_n_o |=> !data_oe_o);
endmodule

// File: tb/tb_bus_slave_top.sv
module tb_bus_slave_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       sel_n = 1'b1, sel = 1'b0, rnw = 1'b0, start_n = 1'b1, irq_req = 1'b0;
  logic [4:0] addr = '0, usr_addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, usr_rdata;
  logic       oe, ack_n, bi_n, irq_n;

  int total = 0, bad = 0;
  logic [7:0] model [32];
  logic       irq_model = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_slave_top dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_n_i(sel_n), .sel_i(sel), .addr_i(addr),
    .rnw_i(rnw), .start_n_i(start_n), .wdata_i(wdata), .rdata_o(rdata),
    .data_oe_o(oe), .ack_n_o(ack_n), .burst_inh_n_o(bi_n), .irq_req_i(irq_req),
    .irq_n_o(irq_n), .usr_addr_i(usr_addr), .usr_rdata_o(usr_rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] expect_rd(input logic [4:0] a);
    return (a == 5'd31) ? {7'b0, irq_model} : model[a];
  endfunction

  // start strobe driven in one cycle, ack checked in the next
  task automatic xfer(input bit rd, input logic [4:0] a, input logic [7:0] d,
                      input bit cs_n, input bit cs, input bit hold_start);
    bit ok_sel;
    ok_sel = !cs_n && cs;
    @(negedge clk);
    sel_n = cs_n; sel = cs; rnw = rd; addr = a; start_n = 1'b0; wdata = d;
    @(negedge clk);
    start_n = hold_start ? 1'b0 : 1'b1;
    addr = $urandom; rnw = $urandom;
    if (ok_sel) begin
      chk(ack_n == 1'b0, "R2", ack_n, 0);
      chk(bi_n == 1'b0, "R3", bi_n, 0);
      chk(oe == rd, "R6", oe, rd);
      if (rd) chk(rdata == expect_rd(a), rd && a == 5'd31 ? "R9" : "R5", rdata, expect_rd(a));
      else if (a != 5'd31) model[a] = d;
    end else begin
      chk(ack_n == 1'b1 && bi_n == 1'b1, "R1", ack_n, 1);
      chk(oe == 1'b0 && rdata == 8'h0, "R6", oe, 0);
    end
    @(negedge clk);
    start_n = 1'b1; sel_n = 1'b1; sel = 1'b0;
    chk(ack_n == 1'b1 && bi_n == 1'b1, hold_start ? "R7" : "R2", ack_n, 1);
    chk(oe == 1'b0, "R6", oe, 0);
    if (ok_sel && !rd) begin
      usr_addr = a;
      #1 chk(usr_rdata == ((a == 5'd31) ? 8'h0 : model[a]), a == 5'd31 ? "R9" : "R4", usr_rdata, model[a]);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 32; i++) model[i] = 8'h0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(ack_n && bi_n && irq_n && !oe, "R10", {ack_n, bi_n, irq_n, oe}, 4'b1110);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      usr_addr = 5'(i);
      #1 chk(usr_rdata == 8'h0, "R10", usr_rdata, 0);
    end
    // directed
    xfer(0, 5'd0, 8'hA5, 0, 1, 0);
    xfer(1, 5'd0, 8'h00, 0, 1, 0);
    xfer(0, 5'd30, 8'h3C, 0, 1, 1);   // R7 start held into ack
    xfer(1, 5'd30, 8'h00, 0, 1, 0);
    xfer(0, 5'd5, 8'hFF, 1, 1, 0);    // R1 sel_n high
    xfer(0, 5'd5, 8'hFF, 0, 0, 0);    // R1 sel low
    xfer(1, 5'd5, 8'h00, 1, 0, 0);    // R1 both wrong
    xfer(0, 5'd31, 8'hFF, 0, 1, 0);   // R9 write ignored
    xfer(1, 5'd31, 8'h00, 0, 1, 0);
    // R8 interrupt synchronizer
    @(negedge clk); irq_req = 1'b1;
    @(negedge clk); chk(irq_n == 1'b1, "R8", irq_n, 1);
    @(negedge clk); chk(irq_n == 1'b0, "R8", irq_n, 0);
    irq_model = 1'b1;
    xfer(1, 5'd31, 8'h00, 0, 1, 0);   // R9 status shows irq
    @(negedge clk); irq_req = 1'b0;
    @(negedge clk); chk(irq_n == 1'b0, "R8", irq_n, 0);
    @(negedge clk); chk(irq_n == 1'b1, "R8", irq_n, 1);
    irq_model = 1'b0;
    xfer(1, 5'd31, 8'h00, 0, 1, 0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      bit cs_n, cs;
      cs_n = ($urandom % 5) == 0;
      cs   = ($urandom % 5) != 0;
      xfer(1'($urandom), 5'($urandom), 8'($urandom), cs_n, cs, ($urandom % 4) == 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule